// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block moves 8-bit channels between sixteen serial input streams and sixteen serial output streams. Every stream carries a frame of 32 channels, 512 master-clock cycles long: each channel takes 16 clocks and each bit cell takes 2 clocks. The switch is non-blocking. Any of the 512 output channels can take any of the 512 input channels, and many outputs may take the same input. Incoming bits are gathered into bytes and stored in a data memory with two banks, chosen by frame parity. A 512-entry connection memory, indexed by output stream and channel, holds one of two things for each output channel: a source address, or a constant byte written by the processor. Each entry also holds the channel's delay mode and its output enable.

A small timing state machine follows the frame sync input. After reset it sits in `SEEK`, where every output is disabled. The first frame sync sampled high takes it through transition `t_lock` into `LOCKED`. In `LOCKED`, each later frame sync, and each wrap of the frame counter, takes transition `t_frame`: the counter goes back to zero and the bank parity flips. Only a reset (`t_reset`) returns the machine to `SEEK`. On the last clock of output channel o−1, the entry for output channel o is looked up and its byte is loaded into a per-stream shifter. For output channel 0, that clock is the last clock of the previous frame.

Top module: `tsi_switch`

## Requirements
- R1: After reset every `tx_oe` bit is 0 until `frame_sync` is sampled high at a rising edge. The cycle after that edge is the first clock of channel 0 of a frame. A frame is 512 clocks, a channel is 16 clocks and a bit cell is 2 clocks.
- R2: Each `rx` bit is sampled at the edge that ends the second clock of its bit cell. The first bit of a channel is its MSB. The byte is stored under its input stream and channel.
- R3: `tx_d[s]` sends the loaded byte MSB first. Bit b of output channel o is shown during frame clocks 16·o+2·(7−b) and 16·o+2·(7−b)+1, and `tx_d` changes only at bit-cell boundaries.
- R4: A write with `wr_en`=1 and `wr_sel`=0 stores `wr_data` in the connection entry at `wr_addr` = {stream[3:0], channel[4:0]}. Entry fields: bits 4:0 source channel, 8:5 source stream, 9 constant delay, 10 processor byte, 11 output enable. After reset all entries are zero.
- R5: A switched entry with variable delay (bit 9 = 0) makes output channel o of frame g carry the source byte received in frame g when the source channel is below o. Otherwise it carries the byte received in frame g−1.
- R6: A switched entry with constant delay (bit 9 = 1) makes every output channel of frame g carry the source byte received in frame g−1.
- R7: Several output channels that name the same source all carry that source's byte.
- R8: An entry with bit 10 = 1 sends its bits 7:0 in every frame. A rewrite takes effect from the next lookup: a write that lands on the last clock of frame g−1 affects channels 1–31 of frame g and channel 0 of frame g+1.
- R9: When the enable bit (bit 11) of the entry loaded for a channel is 0, `tx_oe[s]` is 0 for all 16 clocks of that channel.
- R10: When `drv_en_n` is 1 and the hold bit is 0, all `tx_oe` are 0 regardless of the entries. The hold bit is `wr_data[0]` of a write with `wr_sel`=1 and is 0 after reset. When `drv_en_n` is 0 or the hold bit is 1, the per-channel enables apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, two cycles per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start pulse, sampled high on the last clock before channel 0 |
| rx | input | 16 | Serial input streams |
| drv_en_n | input | 1 | Active-low global output drive enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the connection memory, 1 selects the hold register |
| wr_addr | input | 9 | Connection entry address {stream, channel} |
| wr_data | input | 12 | Entry contents, or the hold bit in bit 0 |
| tx_d | output | 16 | Serial output data |
| tx_oe | output | 16 | Per-stream output drive enable |

## Verification
The bench sends random input bytes on every stream in every frame. Each output channel is compared with the byte the bench predicts from its own entry, source frame and delay rule.

Several directed patterns separate the two delay rules:
- Sources that sit just before and just after the output channel tell the variable-delay frame choice apart from the constant-delay one.
- A constant-delay route from channel 31 into every channel, including channel 0, exercises the same-edge capture path.
- A shared source on eight outputs shows broadcast.

Processor bytes are rewritten at frame boundaries, to expose when a lookup sees the new value. The hold bit and `drv_en_n` step through all four combinations, to separate the global gating from the per-channel enables. A reset in the middle of the run exercises re-lock.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int TSI_STREAMS  = 16;
    localparam int TSI_CHANNELS = 32;
    localparam int TSI_BYTE     = 8;

    typedef enum logic {
        SEEK   = 1'b0,
        LOCKED = 1'b1
    } tb_state_e;
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter int NCH = TSI_CHANNELS,
    parameter int BW  = TSI_BYTE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_sync,
    output logic           locked,
    output logic [$clog2(NCH)-1:0] cur_ch,
    output logic           fpar,
    output logic           smp,
    output logic           load
);
    localparam int BITW = $clog2(BW);
    localparam int CHW  = $clog2(NCH);
    localparam int CNTW = CHW + BITW + 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(NCH * BW * 2 - 1);

    tb_state_e       state, state_n;
    logic [CNTW-1:0] cnt, cnt_n;
    logic            fpar_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEEK;
            cnt   <= '0;
            fpar  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            fpar  <= fpar_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        fpar_n  = fpar;
        unique case (state)
            SEEK: begin
                cnt_n = '0;
                if (frame_sync) state_n = LOCKED;
            end
            LOCKED: begin
                if (frame_sync || cnt == LAST) begin
                    cnt_n  = '0;
                    fpar_n = ~fpar;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        locked = (state == LOCKED);
        cur_ch = cnt[CNTW-1 -: CHW];
        smp    = locked && cnt[0];
        load   = locked && (&cnt[BITW:0]);
    end

    // R1
    lock_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> cnt == '0);

    // R1
    frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) && cnt == '0 |-> fpar != $past(fpar));

    // R1
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) && cnt != '0 |-> $stable(fpar));
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
    import tsi_pkg::*;
#(
    parameter int NSTR = TSI_STREAMS,
    parameter int NCH  = TSI_CHANNELS,
    parameter int BW   = TSI_BYTE
) (
    input  logic                    clk,
    input  logic [NSTR-1:0]         rx,
    input  logic                    smp,
    input  logic                    load,
    input  logic                    fpar,
    input  logic [$clog2(NCH)-1:0]  cur_ch,
    input  logic                    rd_bank [NSTR],
    input  logic [$clog2(NSTR)-1:0] rd_st   [NSTR],
    input  logic [$clog2(NCH)-1:0]  rd_ch   [NSTR],
    output logic [BW-1:0]           rd_byte [NSTR]
);
    logic [BW-1:0] dmem [2][NSTR][NCH];
    logic [BW-1:0] sh   [NSTR];
    logic [BW-1:0] asm_b [NSTR];

    always_comb begin
        for (int s = 0; s < NSTR; s++) asm_b[s] = {sh[s][BW-2:0], rx[s]};
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTR; s++) begin
            if (smp) sh[s] <= asm_b[s];
            if (load) dmem[fpar][s][cur_ch] <= asm_b[s];
        end
    end

    // A slot finishing on this very edge is taken from the assembler.
    always_comb begin
        for (int r = 0; r < NSTR; r++) begin
            if (rd_bank[r] == fpar && rd_ch[r] == cur_ch)
                rd_byte[r] = asm_b[rd_st[r]];
            else
                rd_byte[r] = dmem[rd_bank[r]][rd_st[r]][rd_ch[r]];
        end
    end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
#(
    parameter int NSTR = TSI_STREAMS,
    parameter int NCH  = TSI_CHANNELS,
    parameter int BW   = TSI_BYTE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    locked,
    input  logic                    load,
    input  logic                    smp,
    input  logic                    fpar,
    input  logic [$clog2(NCH)-1:0]  cur_ch,
    input  logic [$clog2(NSTR)+$clog2(NCH)+2:0] entry,
    input  logic [BW-1:0]           rd_byte,
    output logic                    rd_bank,
    output logic [$clog2(NSTR)-1:0] rd_st,
    output logic [$clog2(NCH)-1:0]  rd_ch,
    output logic                    tx_bit,
    output logic                    oe_q
);
    localparam int STW    = $clog2(NSTR);
    localparam int CHW    = $clog2(NCH);
    localparam int CD_BIT = STW + CHW;
    localparam int PC_BIT = CD_BIT + 1;
    localparam int OE_BIT = CD_BIT + 2;
    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    logic [BW-1:0] sh;

    always_comb begin
        rd_ch = entry[CHW-1:0];
        rd_st = entry[CHW +: STW];
        if (entry[CD_BIT])
            rd_bank = (cur_ch == LAST_CH) ? fpar : ~fpar;
        else
            rd_bank = (rd_ch <= cur_ch) ? fpar : ~fpar;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            oe_q <= 1'b0;
        end else if (!locked) begin
            oe_q <= 1'b0;
        end else if (load) begin
            sh   <= entry[PC_BIT] ? entry[BW-1:0] : rd_byte;
            oe_q <= entry[OE_BIT];
        end else if (smp) begin
            sh <= {sh[BW-2:0], 1'b0};
        end
    end

    assign tx_bit = sh[BW-1];

    // R3
    txbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp && $past(locked) |-> $stable(tx_bit));

    // R9
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) && cur_ch == $past(cur_ch) |-> $stable(oe_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTR = TSI_STREAMS,
    parameter int NCH  = TSI_CHANNELS,
    parameter int BW   = TSI_BYTE
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_sync,
    input  logic [NSTR-1:0]                     rx,
    input  logic                                drv_en_n,
    input  logic                                wr_en,
    input  logic                                wr_sel,
    input  logic [$clog2(NSTR)+$clog2(NCH)-1:0] wr_addr,
    input  logic [$clog2(NSTR)+$clog2(NCH)+2:0] wr_data,
    output logic [NSTR-1:0]                     tx_d,
    output logic [NSTR-1:0]                     tx_oe
);
    localparam int STW  = $clog2(NSTR);
    localparam int CHW  = $clog2(NCH);
    localparam int AW   = STW + CHW;
    localparam int ENTW = AW + 3;
    localparam int NENT = NSTR * NCH;

    logic            locked, fpar, smp, load, hold_drv;
    logic [CHW-1:0]  cur_ch, nxt_ch;
    logic [ENTW-1:0] cmem [NENT];
    logic [ENTW-1:0] lane_ent [NSTR];
    logic            rd_bank [NSTR];
    logic [STW-1:0]  rd_st   [NSTR];
    logic [CHW-1:0]  rd_ch   [NSTR];
    logic [BW-1:0]   rd_byte [NSTR];
    logic [NSTR-1:0] lane_oe;

    tsi_timebase #(.NCH(NCH), .BW(BW)) u_tb (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .locked(locked),
        .cur_ch(cur_ch), .fpar(fpar), .smp(smp), .load(load)
    );

    tsi_rx_store #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_rx (
        .clk(clk), .rx(rx), .smp(smp), .load(load), .fpar(fpar), .cur_ch(cur_ch),
        .rd_bank(rd_bank), .rd_st(rd_st), .rd_ch(rd_ch), .rd_byte(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_drv <= 1'b0;
            for (int i = 0; i < NENT; i++) cmem[i] <= '0;
        end else if (wr_en) begin
            if (wr_sel) hold_drv <= wr_data[0];
            else        cmem[wr_addr] <= wr_data;
        end
    end

    assign nxt_ch = cur_ch + 1'b1;

    for (genvar s = 0; s < NSTR; s++) begin : g_lane
        localparam logic [STW-1:0] SI = STW'(s);
        assign lane_ent[s] = cmem[{SI, nxt_ch}];

        tsi_tx_lane #(.NSTR(NSTR), .NCH(NCH), .BW(BW)) u_lane (
            .clk(clk), .rst_n(rst_n), .locked(locked), .load(load), .smp(smp),
            .fpar(fpar), .cur_ch(cur_ch), .entry(lane_ent[s]), .rd_byte(rd_byte[s]),
            .rd_bank(rd_bank[s]), .rd_st(rd_st[s]), .rd_ch(rd_ch[s]),
            .tx_bit(tx_d[s]), .oe_q(lane_oe[s])
        );
    end

    assign tx_oe = lane_oe & {NSTR{locked && (!drv_en_n || hold_drv)}};
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 8;
    localparam int NS = 16;
    localparam int NC = 32;
    localparam int FL = 512;

    logic        clk = 1'b0;
    logic        rst_n, frame_sync, drv_en_n, wr_en, wr_sel;
    logic [15:0] rx;
    logic [8:0]  wr_addr;
    logic [11:0] wr_data;
    logic [15:0] tx_d, tx_oe;

    logic [7:0]  inb [NF][NS][NC];
    logic [11:0] cfg [NF][NS*NC];
    logic        drvf [NF];
    logic        holdf [NF];
    logic        bcast [NS*NC];
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx(rx), .drv_en_n(drv_en_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_d(tx_d), .tx_oe(tx_oe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // entry: [11] enable, [10] processor byte, [9] constant delay, [8:5] src stream, [4:0] src channel (R4)
    function automatic logic [11:0] mk(bit oe, bit pc, bit cd, int st, int ch, logic [7:0] b);
        logic [11:0] e;
        e = {oe, pc, cd, 4'(st), 5'(ch)};
        if (pc) e[7:0] = b;
        return e;
    endfunction

    function automatic logic [11:0] ent_at(int g, int s, int o);
        return (o == 0) ? cfg[g-1][s*NC+o] : cfg[g][s*NC+o];
    endfunction

    function automatic bit exp_oe(int g, int s, int o);
        logic [11:0] e;
        if (g == 0 && o == 0) return 1'b0;
        e = ent_at(g, s, o);
        return e[11] && (!drvf[g] || holdf[g]);
    endfunction

    task automatic build_cfg();
        for (int s = 0; s < NS; s++) begin
            for (int o = 0; o < NC; o++) begin
                int r = int'($urandom);
                int i = s*NC + o;
                bcast[i] = 1'b0;
                if (s == 12)
                    cfg[0][i] = mk(1'b0, 1'b0, r[0], $urandom%NS, $urandom%NC, 8'h00);
                else if (s == 13)
                    cfg[0][i] = mk(1'b1, 1'b0, 1'b1, 5, 31, 8'h00);
                else if (s == 14)
                    cfg[0][i] = mk(1'b1, 1'b0, 1'b0, 2, (o % 2 == 0) ? ((o + NC - 1) % NC) : o, 8'h00);
                else if (s == 15 && o < 8) begin
                    cfg[0][i] = mk(1'b1, 1'b0, o[0], 3, 9, 8'h00);
                    bcast[i] = 1'b1;
                end else
                    cfg[0][i] = mk((r % 8) != 0, ((r >> 3) % 5) == 0, r[6],
                                   $urandom%NS, $urandom%NC, 8'($urandom));
            end
        end
        for (int g = 0; g < NF; g++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++) inb[g][s][c] = 8'($urandom);
        for (int g = 0; g < NF; g++) begin
            drvf[g]  = (g == 3 || g == 4);
            holdf[g] = (g == 2 || g == 3);
            if (g > 0) begin
                for (int i = 0; i < NS*NC; i++) cfg[g][i] = cfg[g-1][i];
                if (g != 2 && g != 4)
                    cfg[g][($urandom % 12)*NC + $urandom % NC] = mk(1'b1, 1'b1, 1'b0, 0, 0, 8'($urandom));
            end
        end
    endtask

    task automatic run_phase();
        logic [7:0] acc [NS];
        bit         badoe [NS];
        rst_n = 1'b0; frame_sync = 1'b0; drv_en_n = 1'b0; wr_en = 1'b0;
        wr_sel = 1'b0; wr_addr = '0; wr_data = '0; rx = '0;
        build_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_oe == 16'h0, "R1", "tx_oe after reset", tx_oe, 0);
        for (int i = 0; i < NS*NC; i++) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 9'(i); wr_data = cfg[0][i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        check(tx_oe == 16'h0, "R1", "tx_oe while seeking", tx_oe, 0);
        frame_sync = 1'b1;
        for (int s = 0; s < NS; s++) begin acc[s] = '0; badoe[s] = 1'b0; end
        for (int g = 0; g < NF; g++) begin
            for (int k = 0; k < FL; k++) begin
                int o = k / 16;
                @(negedge clk);
                if (k % 2 == 0) begin
                    for (int s = 0; s < NS; s++) begin
                        acc[s] = {acc[s][6:0], tx_d[s]};
                        if (tx_oe[s] != exp_oe(g, s, o)) badoe[s] = 1'b1;
                    end
                end
                if (k % 16 == 15) begin
                    for (int s = 0; s < NS; s++) begin
                        bit e_oe = exp_oe(g, s, o);
                        if (!(g == 0 && o == 0)) begin
                            logic [11:0] e = ent_at(g, s, o);
                            string tg;
                            int sf;
                            logic [7:0] xb;
                            bit valid = 1'b1;
                            if (e[10]) begin
                                xb = e[7:0]; tg = "R8,R3";
                            end else begin
                                sf = e[9] ? g - 1 : ((int'(e[4:0]) < o) ? g : g - 1);
                                valid = (sf >= 0);
                                xb = valid ? inb[sf][e[8:5]][e[4:0]] : 8'h00;
                                tg = bcast[s*NC+o] ? "R7,R2" : (e[9] ? "R6,R2" : "R5,R2");
                            end
                            if (valid)
                                check(acc[s] == xb, tg, $sformatf("data g%0d s%0d ch%0d", g, s, o), acc[s], xb);
                            check(!badoe[s], e[11] ? "R10" : "R9",
                                  $sformatf("enable g%0d s%0d ch%0d", g, s, o), !e_oe, e_oe);
                        end else begin
                            check(!badoe[s], "R1", $sformatf("first channel enable s%0d", s), !e_oe, e_oe);
                        end
                        badoe[s] = 1'b0;
                    end
                end
                frame_sync = (k == FL - 1);
                for (int s = 0; s < NS; s++)
                    rx[s] = inb[g][s][k/16][7 - (k % 16) / 2];
                wr_en = 1'b0;
                if (k == FL - 1 && g + 1 < NF) begin
                    drv_en_n = drvf[g+1];
                    if (holdf[g+1] != holdf[g]) begin
                        wr_en = 1'b1; wr_sel = 1'b1; wr_data = {11'h0, holdf[g+1]};
                    end else begin
                        for (int i = 0; i < NS*NC; i++) begin
                            if (cfg[g+1][i] != cfg[g][i]) begin
                                wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 9'(i); wr_data = cfg[g+1][i];
                            end
                        end
                    end
                end
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        run_phase();
        run_phase();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule